// File: doc/BRIEF.md
# SMBus Clock-High Timeout Monitor

This block opens a transaction on a two-wire SMBus/I2C bus and guards it against a clock line that stays high too long. On a start request from the controller's control logic, it waits one SCL-low period with both lines released. It then pulls SDA low to form the START condition. After one more SCL-low period it pulls SCL low, and from that point it generates the bit clock from the configured low and high periods. All periods are counted in ticks of an external clock divider. The line outputs are open-drain enables: 1 pulls the wire low.

A high-time counter measures how long SCL stays high while the bus is busy. It reloads on every observed SCL falling edge and counts one per tick while the sampled line is high. When the count runs out, the block emits a one-cycle timeout event, sets a sticky flag and drops the sequencer back to idle, which releases both lines. With the default limit of 500 ticks at a 100 ns tick, the bound is 50 µs. A mode input selects when the counter arms. In legacy mode it arms at the start request, so slow bus clocks, whose two START low periods together exceed the limit, trip it falsely. In fixed mode it arms only at the first SCL falling edge of the transaction. Before use, SCL is passed through a two-flop synchronizer, so a target that stretches the clock is seen as it really is.

FSM states: `ST_IDLE`, `ST_SETUP` (lines released, first low period), `ST_HOLD` (SDA low, second low period), `ST_LOW` (SCL driven low) and `ST_HIGH` (SCL released). The transitions are:
- IDLE→SETUP on an accepted start.
- SETUP→HOLD and HOLD→LOW after `low_ticks` ticks.
- LOW→HIGH after `low_ticks` ticks.
- HIGH→LOW after `high_ticks` ticks counted while SCL is sampled high.
- Any busy state→IDLE on timeout expiry or on `stop_req`.

Top module: `smbht_monitor`

## Requirements
- R1: After reset, `sda_oe` and `scl_oe` are 0, `busy` is 0, and `tmo_evt` and `tmo_flag` are 0.
- R2: After an accepted start request, `sda_oe` goes to 1 after `low_ticks` ticks, and `scl_oe` goes to 1 after a further `low_ticks` ticks while `sda_oe` stays 1.
- R3: During the transfer, `scl_oe` stays 1 for `low_ticks` ticks. It then stays 0 for `high_ticks` ticks counted only once the synchronized SCL line reads high, so time a target holds SCL low lengthens the high phase.
- R4: With `mode_fixed`=0 (legacy), the high-time counter loads `tmo_limit` at the accepted start and counts the START phase, so it expires during START generation whenever 2·`low_ticks` exceeds `tmo_limit`.
- R5: With `mode_fixed`=1, the counter is armed only from the first synchronized SCL falling edge, so no timeout occurs during START generation, whatever `low_ticks` is.
- R6: The counter reloads to `tmo_limit` on every SCL falling edge, and expires after `tmo_limit` ticks of continuous sampled-high SCL. High phases shorter than the limit never trip, however many occur.
- R7: On expiry, `tmo_evt` is high for exactly one cycle. In that cycle `busy` is already 0 and both line enables are 0.
- R8: `tmo_flag` is set by expiry and holds until `tmo_clr` is 1. Expiry wins if both occur in the same cycle.
- R9: A start request while `busy` is 1 is ignored: it neither restarts the sequence nor reloads the counter.
- R10: `stop_req` while busy returns the FSM to idle, releasing both lines and clearing `busy`.
- R11: While idle, nothing is counted and no timeout event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time base from the clock divider |
| mode_fixed | input | 1 | 0: arm at start request; 1: arm at first SCL fall |
| low_ticks | input | CW | SCL-low period in ticks |
| high_ticks | input | CW | SCL-high period in ticks |
| tmo_limit | input | TW | Maximum SCL-high time in ticks |
| start_req | input | 1 | Start request from the control register |
| stop_req | input | 1 | Ends the transfer, returns to idle |
| tmo_clr | input | 1 | Write-one-to-clear for the sticky flag |
| scl_in | input | 1 | Sensed SCL wire level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| busy | output | 1 | Sequencer outside idle |
| tmo_evt | output | 1 | One-cycle timeout event |
| tmo_flag | output | 1 | Sticky timeout status |

## Verification
The bench sets a slow bus clock (300-tick low, 200-tick high, 500-tick limit) in both modes. In legacy mode it expects a trip before SCL is ever pulled low. In fixed mode it expects three full bits with no trip. A counter that never reloads would trip on the cumulative 600 high ticks. A counter armed at the request in fixed mode would reproduce the false trip. A second start request issued mid-START must leave the trip time unmoved; a design that accepts it shows a late or missing event. A target stretch of SCL must lengthen the high phase rather than shorten it, which exposes a sequencer that counts from its own release instead of the sampled line.

// File: rtl/smbht_pkg.sv
package smbht_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HOLD  = 3'd2,
        ST_LOW   = 3'd3,
        ST_HIGH  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/smbht_sync.sv
module smbht_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic line_fall
);
    logic meta_q, sync_q, prev_q;

    // The bus idles high, so every flop resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s    = sync_q;
    assign line_fall = prev_q & ~sync_q;
endmodule

// File: rtl/smbht_seq.sv
module smbht_seq
    import smbht_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          expire,
    input  logic          scl_s,
    input  logic [CW-1:0] low_ticks,
    input  logic [CW-1:0] high_ticks,
    output logic          sda_oe,
    output logic          scl_oe,
    output logic          busy
);
    localparam int PW = CW + 1;

    seq_state_t    state_q, state_d;
    logic [CW-1:0] ph_q, ph_d;
    logic          low_done, high_done;

    // Phase-complete flags, widened by one bit so a zero period cannot wrap.
    assign low_done  = ({1'b0, ph_q} + PW'(1)) >= {1'b0, low_ticks};
    assign high_done = ({1'b0, ph_q} + PW'(1)) >= {1'b0, high_ticks};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ST_SETUP;
                    ph_d    = '0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    if (low_done) begin
                        state_d = ST_HOLD;
                        ph_d    = '0;
                    end else begin
                        ph_d = ph_q + CW'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (low_done) begin
                        state_d = ST_LOW;
                        ph_d    = '0;
                    end else begin
                        ph_d = ph_q + CW'(1);
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    if (low_done) begin
                        state_d = ST_HIGH;
                        ph_d    = '0;
                    end else begin
                        ph_d = ph_q + CW'(1);
                    end
                end
            end
            ST_HIGH: begin
                // The high phase only advances while the line is seen high (stretch aware).
                if (tick && scl_s) begin
                    if (high_done) begin
                        state_d = ST_LOW;
                        ph_d    = '0;
                    end else begin
                        ph_d = ph_q + CW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                ph_d    = '0;
            end
        endcase
        if (state_q != ST_IDLE && (expire || stop_req)) begin
            state_d = ST_IDLE;
            ph_d    = '0;
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        scl_oe = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_SETUP: ;
            ST_HOLD:  sda_oe = 1'b1;
            ST_LOW: begin
                sda_oe = 1'b1;
                scl_oe = 1'b1;
            end
            ST_HIGH:  sda_oe = 1'b1;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/smbht_hitimer.sv
module smbht_hitimer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_fixed,
    input  logic [TW-1:0] limit,
    input  logic          accept,
    input  logic          busy,
    input  logic          scl_s,
    input  logic          scl_fall,
    input  logic          clr,
    output logic          expire,
    output logic          evt,
    output logic          flag
);
    logic [TW-1:0] cnt_q;
    logic          armed_q;
    logic          count_en;

    assign count_en = tick && armed_q && busy && scl_s;
    assign expire   = count_en && (cnt_q <= TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            evt     <= 1'b0;
            flag    <= 1'b0;
        end else begin
            if (accept) begin
                cnt_q   <= limit;
                armed_q <= !mode_fixed;
            end else if (!busy || expire) begin
                armed_q <= 1'b0;
            end else if (scl_fall) begin
                cnt_q   <= limit;
                armed_q <= 1'b1;
            end else if (count_en) begin
                cnt_q <= cnt_q - TW'(1);
            end
            evt <= expire;
            if (expire)   flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/smbht_monitor.sv
module smbht_monitor #(
    parameter int CW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_fixed,
    input  logic [CW-1:0] low_ticks,
    input  logic [CW-1:0] high_ticks,
    input  logic [TW-1:0] tmo_limit,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          tmo_clr,
    input  logic          scl_in,
    output logic          sda_oe,
    output logic          scl_oe,
    output logic          busy,
    output logic          tmo_evt,
    output logic          tmo_flag
);
    logic scl_s, scl_fall, expire, accept;

    // A start request only counts while the sequencer is idle.
    assign accept = start_req && !busy;

    smbht_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_s    (scl_s),
        .line_fall (scl_fall)
    );

    smbht_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .expire     (expire),
        .scl_s      (scl_s),
        .low_ticks  (low_ticks),
        .high_ticks (high_ticks),
        .sda_oe     (sda_oe),
        .scl_oe     (scl_oe),
        .busy       (busy)
    );

    smbht_hitimer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode_fixed (mode_fixed),
        .limit      (tmo_limit),
        .accept     (accept),
        .busy       (busy),
        .scl_s      (scl_s),
        .scl_fall   (scl_fall),
        .clr        (tmo_clr),
        .expire     (expire),
        .evt        (tmo_evt),
        .flag       (tmo_flag)
    );
endmodule

// File: rtl/smbht_monitor_chk.sv
module smbht_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic tmo_clr,
    input logic sda_oe,
    input logic scl_oe,
    input logic busy,
    input logic tmo_evt,
    input logic tmo_flag
);
    p_sda_before_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> sda_oe);

    p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> !tmo_evt);

    p_evt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |-> (!busy && !sda_oe && !scl_oe));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |-> tmo_flag);

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !tmo_clr) |=> tmo_flag);

    p_no_evt_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !tmo_evt);
endmodule

bind smbht_monitor smbht_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmo_clr  (tmo_clr),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .busy     (busy),
    .tmo_evt  (tmo_evt),
    .tmo_flag (tmo_flag)
);

// File: tb/smbht_monitor_tb_top.sv
`timescale 1ns/1ps
module smbht_monitor_tb_top;
    localparam int CW = 16;
    localparam int TW = 16;
    localparam int TDIV = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          mode_fixed = 1'b0;
    logic [CW-1:0] low_ticks = 16'd20;
    logic [CW-1:0] high_ticks = 16'd15;
    logic [TW-1:0] tmo_limit = 16'd500;
    logic          start_req = 1'b0;
    logic          stop_req = 1'b0;
    logic          tmo_clr = 1'b0;
    logic          stretch = 1'b0;
    logic          scl_in;
    logic          sda_oe, scl_oe, busy, tmo_evt, tmo_flag;

    int total = 0;
    int bad = 0;
    int evt_cnt = 0;
    int evt_wide = 0;
    logic evt_prev = 1'b0;
    logic done = 1'b0;

    assign scl_in = !(scl_oe || stretch);

    always #10 clk = ~clk;

    smbht_monitor #(.CW(CW), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_fixed(mode_fixed),
        .low_ticks(low_ticks), .high_ticks(high_ticks), .tmo_limit(tmo_limit),
        .start_req(start_req), .stop_req(stop_req), .tmo_clr(tmo_clr),
        .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe), .busy(busy),
        .tmo_evt(tmo_evt), .tmo_flag(tmo_flag)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick = (div == TDIV - 1);
            div = (div == TDIV - 1) ? 0 : div + 1;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (tmo_evt) evt_cnt++;
            if (tmo_evt && evt_prev) evt_wide++;
            evt_prev = tmo_evt;
        end
    end

    task automatic chk_eq(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(string tag, int act, int lo, int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic setup(logic fx, int lo, int hi, int lim);
        @(negedge clk);
        mode_fixed = fx;
        low_ticks  = CW'(lo);
        high_ticks = CW'(hi);
        tmo_limit  = TW'(lim);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); tmo_clr = 1'b1;
        @(negedge clk); tmo_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 sda_oe", int'(sda_oe), 0);
        chk_eq("R1 scl_oe", int'(scl_oe), 0);
        chk_eq("R1 busy", int'(busy), 0);
        chk_eq("R1 tmo_flag", int'(tmo_flag), 0);
    endtask

    task automatic t_idle();
        int e0 = evt_cnt;
        repeat (3000) @(negedge clk);
        chk_eq("R11 idle events", evt_cnt - e0, 0);
        chk_eq("R11 idle flag", int'(tmo_flag), 0);
    endtask

    task automatic t_start_seq();
        int n;
        setup(1'b1, 20, 15, 500);
        pulse_start();
        n = 0;
        while (!sda_oe && n < 1000) begin @(negedge clk); n++; end
        chk_rng("R2 start to SDA low", n, 94, 106);
        n = 0;
        while (!scl_oe && n < 1000) begin @(negedge clk); n++; chk_eq("R2 SDA held", int'(sda_oe), 1); end
        chk_rng("R2 SDA low to SCL low", n, 94, 106);
        n = 0;
        while (scl_oe && n < 1000) begin @(negedge clk); n++; end
        chk_rng("R3 SCL low phase", n, 94, 106);
        n = 0;
        while (!scl_oe && n < 1000) begin @(negedge clk); n++; end
        chk_rng("R3 SCL high phase", n, 71, 84);
        do_stop();
        chk_eq("R10 busy after stop", int'(busy), 0);
        chk_eq("R10 lines released", int'(sda_oe || scl_oe), 0);
    endtask

    task automatic t_stretch();
        int n;
        int e0 = evt_cnt;
        setup(1'b1, 20, 15, 500);
        pulse_start();
        n = 0;
        while (!scl_oe && n < 1000) begin @(negedge clk); n++; end
        stretch = 1'b1;
        n = 0;
        while (scl_oe && n < 1000) begin @(negedge clk); n++; end
        repeat (300) @(negedge clk);
        stretch = 1'b0;
        n = 0;
        while (!scl_oe && n < 1000) begin @(negedge clk); n++; end
        chk_rng("R3 high phase after stretch", n, 71, 84);
        chk_eq("R3 no timeout while stretched", evt_cnt - e0, 0);
        do_stop();
    endtask

    task automatic t_legacy_slow();
        int n = 0;
        logic saw_scl = 1'b0;
        setup(1'b0, 300, 200, 500);
        pulse_start();
        while (!tmo_evt && n < 5000) begin
            @(negedge clk); n++;
            if (scl_oe) saw_scl = 1'b1;
        end
        chk_rng("R4 legacy trip time", n, 2490, 2510);
        chk_eq("R4 trip before SCL low", int'(saw_scl), 0);
        chk_eq("R7 busy at event", int'(busy), 0);
        chk_eq("R7 lines at event", int'(sda_oe || scl_oe), 0);
        @(negedge clk);
        chk_eq("R7 event width", int'(tmo_evt), 0);
        chk_eq("R8 flag set", int'(tmo_flag), 1);
        repeat (20) @(negedge clk);
        chk_eq("R8 flag holds", int'(tmo_flag), 1);
        clear_flag();
        @(negedge clk);
        chk_eq("R8 flag cleared", int'(tmo_flag), 0);
    endtask

    task automatic t_restart_ignored();
        int n = 0;
        setup(1'b0, 300, 200, 500);
        pulse_start();
        repeat (2000) begin @(negedge clk); n++; end
        start_req = 1'b1; @(negedge clk); n++;
        start_req = 1'b0;
        while (!tmo_evt && n < 6000) begin @(negedge clk); n++; end
        chk_rng("R9 trip time unchanged by second start", n, 2490, 2510);
        clear_flag();
    endtask

    task automatic t_fixed_slow();
        int n = 0;
        int falls = 0;
        logic prev = 1'b0;
        int e0 = evt_cnt;
        setup(1'b1, 300, 200, 500);
        pulse_start();
        while (falls < 4 && n < 20000) begin
            @(negedge clk); n++;
            if (scl_oe && !prev) falls++;
            prev = scl_oe;
        end
        chk_eq("R5 SCL falls reached", falls, 4);
        chk_eq("R5 no false trip", evt_cnt - e0, 0);
        chk_eq("R6 reload keeps transfer alive", int'(busy), 1);
        do_stop();
        chk_eq("R10 stop releases", int'(busy || sda_oe || scl_oe), 0);
    endtask

    task automatic t_fixed_long_high();
        int n;
        setup(1'b1, 50, 600, 500);
        pulse_start();
        n = 0;
        while (!scl_oe && n < 2000) begin @(negedge clk); n++; end
        n = 0;
        while (scl_oe && n < 2000) begin @(negedge clk); n++; end
        n = 0;
        while (!tmo_evt && n < 5000) begin @(negedge clk); n++; end
        chk_rng("R6 trip after limit ticks of high", n, 2490, 2515);
        chk_eq("R7 idle after trip", int'(busy), 0);
        chk_eq("R8 flag after trip", int'(tmo_flag), 1);
        clear_flag();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_start_seq();
        t_stretch();
        t_legacy_slow();
        t_restart_ignored();
        t_fixed_slow();
        t_fixed_long_high();
        chk_eq("R7 event pulses wider than one cycle", evt_wide, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired before completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule